// File: doc/BRIEF.md
# Weighted Round-Robin Thread Slot Scheduler

This block chooses which of four hardware thread contexts owns a shared pipeline in each clock cycle. Time is divided into rounds of fixed length, normally set to the worst-case memory latency. A memory request that a thread starts in its slot therefore completes before that thread's turn in the following round. Within a round every thread owns one contiguous slot of programmed length, in ascending thread order. When a slot ends the block forces a switch, whether or not the thread is still computing. Other threads' memory transfers carry on in the background while a thread computes.

Software writes slot and round lengths into staging registers. The staged set is checked continuously: if the slot lengths add up to more than the round, or the round is zero, an error flag is raised and the staged set is refused. A valid staged set is copied into the active set only on the final cycle of a round, so a round always runs with one consistent configuration. Cycles owned by a disabled thread, cycles of a zero-length slot, and cycles left over after the last slot are idle. Idle cycles are not handed to another thread.

Top module: `wrr_slot_sched`

## Requirements
- R1: During reset `round_start`, `vp_valid` and `preempt` are low. On the first cycle after reset is released, a round begins: `round_start` is high, and thread 0 owns the cycle if it is enabled and has a nonzero slot.
- R2: `round_start` is high for exactly one cycle at the start of every round, and consecutive rounds start exactly the active round length apart.
- R3: With active slot lengths L0..L3, thread k owns the round positions from L0+..+L(k-1) up to, but not including, that sum plus Lk. `vp_id` reports k and `vp_valid` is high for each of those cycles.
- R4: `preempt` is high for one cycle on the last cycle of every nonzero slot of an enabled thread. This holds even when nothing else happens in that cycle, and on the next cycle another thread, idle, or a new round follows.
- R5: In cycles that fall in the slot of a disabled thread (its `vp_en` bit is 0) or of a zero-length slot, `vp_valid` and `preempt` are low. No other thread is reported.
- R6: When the slots sum to less than the round length, the remaining cycles at the end of the round have `vp_valid` low.
- R7: A configuration write changes the schedule only from the next round boundary on. The rest of the current round keeps the old slot positions.
- R8: `cfg_err` is high while the staged slots sum to more than the staged round length, or the staged round length is zero. A staged set in that state is never made active, and the previous active set stays in force.
- R9: `cfg_sel` values 0 to 3 write the slot length of that thread and value 4 writes the round length. All other codes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Staging register select (0-3 slot, 4 round) |
| cfg_data | input | 8 | Value written, in cycles |
| vp_en | input | 4 | Per-thread enable, one bit per thread |
| vp_valid | output | 1 | A thread owns the pipeline this cycle |
| vp_id | output | 2 | Index of the owning thread |
| round_start | output | 1 | First cycle of a round |
| preempt | output | 1 | Last cycle of the current slot |
| cfg_err | output | 1 | Staged configuration is inconsistent |

## Verification
Two events can coincide. A configuration write can land in the same cycle as the round-boundary copy, and a slot's preemption can be followed at once by the next round start when the last slot fills the round. The bench writes a new slot length in the middle of a round and compares every remaining position of that round against the old schedule, then the first cycles of the next round against the new one. A refused configuration is judged by running full rounds and showing the old slot map still applies.

// File: rtl/wrr_pkg.sv
package wrr_pkg;

    // Staging register select codes: codes below the thread count pick a slot,
    // the code equal to the thread count picks the round length.
    function automatic int unsigned round_sel_code(input int unsigned num_vp);
        return num_vp;
    endfunction

    typedef struct packed {
        logic round_start;
        logic valid;
        logic preempt;
    } sched_flags_t;

endpackage

// File: rtl/wrr_cfg_shadow.sv
module wrr_cfg_shadow #(
    parameter int NUM_VP    = 4,
    parameter int CNT_W     = 8,
    parameter int RST_SLOT  = 2,
    parameter int RST_ROUND = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_wr,
    input  logic [$clog2(NUM_VP+1)-1:0]      cfg_sel,
    input  logic [CNT_W-1:0]                 cfg_data,
    input  logic                             load,
    output logic [NUM_VP-1:0][CNT_W-1:0]     act_slot,
    output logic [CNT_W-1:0]                 act_round,
    output logic                             cfg_err
);
    import wrr_pkg::*;

    localparam int SEL_W = $clog2(NUM_VP + 1);
    localparam int SUM_W = CNT_W + $clog2(NUM_VP + 1);
    localparam logic [SEL_W-1:0] ROUND_SEL = SEL_W'(round_sel_code(NUM_VP));

    typedef struct packed {
        logic [NUM_VP-1:0][CNT_W-1:0] stg_slot;
        logic [CNT_W-1:0]             stg_round;
        logic [NUM_VP-1:0][CNT_W-1:0] act_slot;
        logic [CNT_W-1:0]             act_round;
    } shadow_t;

    shadow_t          s_d, s_q;
    logic [SUM_W-1:0] stg_sum;
    logic             stg_bad;

    always_comb begin
        stg_sum = '0;
        for (int i = 0; i < NUM_VP; i++) begin
            stg_sum = stg_sum + SUM_W'(s_q.stg_slot[i]);
        end
        stg_bad = (s_q.stg_round == '0) || (stg_sum > SUM_W'(s_q.stg_round));
    end

    always_comb begin
        s_d = s_q;
        if (cfg_wr) begin
            for (int i = 0; i < NUM_VP; i++) begin
                if (cfg_sel == SEL_W'(i)) begin
                    s_d.stg_slot[i] = cfg_data;
                end
            end
            if (cfg_sel == ROUND_SEL) begin
                s_d.stg_round = cfg_data;
            end
        end
        if (load && !stg_bad) begin
            s_d.act_slot  = s_q.stg_slot;
            s_d.act_round = s_q.stg_round;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.stg_slot  <= {NUM_VP{CNT_W'(RST_SLOT)}};
            s_q.stg_round <= CNT_W'(RST_ROUND);
            s_q.act_slot  <= {NUM_VP{CNT_W'(RST_SLOT)}};
            s_q.act_round <= CNT_W'(RST_ROUND);
        end else begin
            s_q <= s_d;
        end
    end

    assign act_slot  = s_q.act_slot;
    assign act_round = s_q.act_round;
    assign cfg_err   = stg_bad;

    logic [SUM_W-1:0] act_sum;
    always_comb begin
        act_sum = '0;
        for (int i = 0; i < NUM_VP; i++) begin
            act_sum = act_sum + SUM_W'(s_q.act_slot[i]);
        end
    end

    // R7: the active set moves only on a round boundary
    assert_hold_mid_round_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(act_slot) && $stable(act_round)));

    // R8: a refused staged set leaves the active set untouched
    assert_reject_bad_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && cfg_err) |=> ($stable(act_slot) && $stable(act_round)));

    // R8: the active set always fits its round
    assert_active_fits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (act_round != '0) && (act_sum <= SUM_W'(act_round)));

endmodule

// File: rtl/wrr_slot_decode.sv
module wrr_slot_decode #(
    parameter int NUM_VP = 4,
    parameter int CNT_W  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         run,
    input  logic [CNT_W-1:0]             pos,
    input  logic [NUM_VP-1:0][CNT_W-1:0] act_slot,
    input  logic [NUM_VP-1:0]            vp_en,
    output logic                         vp_valid,
    output logic [$clog2(NUM_VP)-1:0]    vp_id,
    output logic                         preempt
);
    localparam int ID_W  = $clog2(NUM_VP);
    localparam int SUM_W = CNT_W + $clog2(NUM_VP + 1);

    logic [NUM_VP-1:0] hit;
    logic [NUM_VP-1:0] last;

    always_comb begin
        logic [SUM_W-1:0] base;
        logic [SUM_W-1:0] top;
        logic [SUM_W-1:0] p;
        base = '0;
        p    = SUM_W'(pos);
        hit  = '0;
        last = '0;
        for (int i = 0; i < NUM_VP; i++) begin
            top = base + SUM_W'(act_slot[i]);
            hit[i]  = run && vp_en[i] && (act_slot[i] != '0) && (p >= base) && (p < top);
            last[i] = hit[i] && (p == top - SUM_W'(1));
            base = top;
        end
    end

    always_comb begin
        vp_id = '0;
        for (int i = 0; i < NUM_VP; i++) begin
            if (hit[i]) begin
                vp_id = ID_W'(i);
            end
        end
    end

    assign vp_valid = |hit;
    assign preempt  = |last;

    // R3: at most one thread owns any cycle
    assert_single_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    // R4: a preemption only ends an owned slot
    assert_preempt_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        preempt |-> vp_valid);

endmodule

// File: rtl/wrr_slot_sched.sv
module wrr_slot_sched #(
    parameter int NUM_VP    = 4,
    parameter int CNT_W     = 8,
    parameter int RST_SLOT  = 2,
    parameter int RST_ROUND = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_wr,
    input  logic [$clog2(NUM_VP+1)-1:0]   cfg_sel,
    input  logic [CNT_W-1:0]              cfg_data,
    input  logic [NUM_VP-1:0]             vp_en,
    output logic                          vp_valid,
    output logic [$clog2(NUM_VP)-1:0]     vp_id,
    output logic                          round_start,
    output logic                          preempt,
    output logic                          cfg_err
);
    import wrr_pkg::*;

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] pos;
    } ctr_t;

    ctr_t                         c_d, c_q;
    logic                         load;
    logic [NUM_VP-1:0][CNT_W-1:0] act_slot;
    logic [CNT_W-1:0]             act_round;
    sched_flags_t                 flags;

    assign load = c_q.run && (c_q.pos == act_round - CNT_W'(1));

    always_comb begin
        c_d = c_q;
        if (!c_q.run) begin
            c_d.run = 1'b1;
            c_d.pos = '0;
        end else if (load) begin
            c_d.pos = '0;
        end else begin
            c_d.pos = c_q.pos + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.run <= 1'b0;
            c_q.pos <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    wrr_cfg_shadow #(
        .NUM_VP   (NUM_VP),
        .CNT_W    (CNT_W),
        .RST_SLOT (RST_SLOT),
        .RST_ROUND(RST_ROUND)
    ) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_sel  (cfg_sel),
        .cfg_data (cfg_data),
        .load     (load),
        .act_slot (act_slot),
        .act_round(act_round),
        .cfg_err  (cfg_err)
    );

    wrr_slot_decode #(
        .NUM_VP(NUM_VP),
        .CNT_W (CNT_W)
    ) u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (c_q.run),
        .pos     (c_q.pos),
        .act_slot(act_slot),
        .vp_en   (vp_en),
        .vp_valid(flags.valid),
        .vp_id   (vp_id),
        .preempt (flags.preempt)
    );

    assign flags.round_start = c_q.run && (c_q.pos == '0);
    assign round_start = flags.round_start;
    assign vp_valid    = flags.valid;
    assign preempt     = flags.preempt;

    // R2: the round position never reaches the active round length
    assert_pos_in_round_R2: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.run |-> (c_q.pos < act_round));

    // R4: after a preemption the owner changes, goes idle, or a round restarts
    assert_forced_switch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        preempt |=> (round_start || !vp_valid || (vp_id != $past(vp_id))));

    // R1: no output activity before the first round
    assert_quiet_before_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !c_q.run |-> (!vp_valid && !round_start && !preempt));

endmodule

// File: tb/wrr_slot_sched_tb.sv
module wrr_slot_sched_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ROUND_LEN  = 12;
    localparam int WATCHDOG   = 200000;

    // Expected map for slots {3,2,0,4}, round 12: {valid, vp[1:0], preempt}
    localparam logic [3:0] EXP_TBL [ROUND_LEN] = '{
        4'b1000, 4'b1000, 4'b1001, 4'b1010, 4'b1011, 4'b1110,
        4'b1110, 4'b1110, 4'b1111, 4'b0000, 4'b0000, 4'b0000
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [7:0] cfg_data = '0;
    logic [3:0] vp_en = 4'b1111;
    logic       vp_valid;
    logic [1:0] vp_id;
    logic       round_start;
    logic       preempt;
    logic       cfg_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wrr_slot_sched u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_sel    (cfg_sel),
        .cfg_data   (cfg_data),
        .vp_en      (vp_en),
        .vp_valid   (vp_valid),
        .vp_id      (vp_id),
        .round_start(round_start),
        .preempt    (preempt),
        .cfg_err    (cfg_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Observed state packed as {round_start, valid, vp, preempt}
    function automatic int obs();
        return {round_start, vp_valid, (vp_valid ? vp_id : 2'b00), preempt};
    endfunction

    function automatic int exp_at(input int p, input logic [3:0] en);
        logic [3:0] e;
        e = EXP_TBL[p];
        if (e[3] && !en[e[2:1]]) e = 4'b0000;
        return {(p == 0), e};
    endfunction

    task automatic write_cfg(input logic [2:0] sel, input logic [7:0] data);
        cfg_wr   = 1'b1;
        cfg_sel  = sel;
        cfg_data = data;
        @(negedge clk);
        cfg_wr   = 1'b0;
    endtask

    task automatic wait_rs();
        do @(negedge clk); while (!round_start);
    endtask

    task automatic check_round(input string req, input logic [3:0] en);
        wait_rs();
        for (int p = 0; p < ROUND_LEN; p++) begin
            if (p != 0) @(negedge clk);
            chk(req, obs(), exp_at(p, en));
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: quiet during reset
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {round_start, vp_valid, preempt}, 0);
        rst_n = 1'b1;
        // R1/R3/R4: default round, four slots of 2 in an 8-cycle round
        for (int p = 0; p < 8; p++) begin
            @(negedge clk);
            chk("R1 R3 R4 default round", obs(),
                {(p == 0), 1'b1, 2'(p / 2), (p % 2 == 1)});
        end

        // R9/R8: round length first, then slots {3,2,0,4}
        write_cfg(3'd4, 8'd12);
        write_cfg(3'd0, 8'd3);
        write_cfg(3'd1, 8'd2);
        write_cfg(3'd2, 8'd0);
        write_cfg(3'd3, 8'd4);
        chk("R8 consistent set clears error", cfg_err, 0);

        // R3 R4 R5 R6: table walk, zero slot and trailing idle cycles
        check_round("R3 R4 R5 R6 table", 4'b1111);

        // R2: round period
        begin
            int n = 0;
            wait_rs();
            do begin @(negedge clk); n++; end while (!round_start);
            chk("R2 round period", n, ROUND_LEN);
        end

        // R5: disabled thread leaves its slot idle
        vp_en = 4'b1101;
        check_round("R5 disabled thread", 4'b1101);
        vp_en = 4'b1111;

        // R9: unused select code changes nothing
        write_cfg(3'd5, 8'd1);
        write_cfg(3'd7, 8'd200);
        chk("R9 unused code no error", cfg_err, 0);
        check_round("R9 unused code keeps map", 4'b1111);

        // R8: oversubscribed slots are flagged and refused
        write_cfg(3'd2, 8'd5);
        chk("R8 oversubscription flagged", cfg_err, 1);
        check_round("R8 old map retained", 4'b1111);
        check_round("R8 old map retained again", 4'b1111);
        write_cfg(3'd4, 8'd0);
        chk("R8 zero round flagged", cfg_err, 1);
        write_cfg(3'd2, 8'd0);
        write_cfg(3'd4, 8'd12);
        chk("R8 error clears", cfg_err, 0);
        check_round("R8 map after recovery", 4'b1111);

        // R7: write in mid-round, new slot 0 length 1 only from next round
        wait_rs();
        repeat (4) @(negedge clk);
        write_cfg(3'd0, 8'd1);
        for (int p = 5; p < ROUND_LEN; p++) begin
            if (p != 5) @(negedge clk);
            chk("R7 rest of round unchanged", obs(), exp_at(p, 4'b1111));
        end
        @(negedge clk);
        chk("R7 new round slot0 one cycle", obs(), {1'b1, 1'b1, 2'd0, 1'b1});
        @(negedge clk);
        chk("R7 thread1 moves up", obs(), {1'b0, 1'b1, 2'd1, 1'b0});
        write_cfg(3'd0, 8'd3);
        check_round("R7 restored map", 4'b1111);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule